// File: doc/BRIEF.md
# Video Sync Stability Monitor

This block sits in the pixel clock domain behind a video receiver. It watches the recovered horizontal sync, vertical sync and data-enable signals. It measures how many active pixels each line carries and how many active lines each frame carries. Each new measurement is compared with the one before it. When two consecutive measurements disagree, the timing is reported as unstable. When they agree but differ from the programmed expected resolution, the timing is reported as stable but of the wrong size. Keeping these two conditions apart lets software tell a source that is still locking apart from one that is locked to a different mode.

The detected counts are available both as output ports and through a small register read port. Four sticky status flags record the events. Software clears a flag by writing one to its bit. A detected count can be trusted only while the out-of-sync flag for its own axis is clear. For a 1080p source, software would program 1920 pixels and 1080 lines as the expected counts.

Top module: `sync_stab_mon`

## Requirements
- R1: After synchronous reset, the status flags, both detected counts and the read data are all zero.
- R2: A horizontal measurement is the number of cycles with data enable high between two consecutive rising edges of hsync. An interval with no data-enable cycle produces no measurement. The latest measurement is driven on det_h.
- R3: A vertical measurement is the number of falling edges of data enable (active lines) between two consecutive rising edges of vsync. An interval with no active line produces no measurement. The latest measurement is driven on det_v.
- R4: Status bit 2 (horizontal out-of-sync) is set when a horizontal measurement differs from the previous one.
- R5: Status bit 3 (vertical out-of-sync) is set when a vertical measurement differs from the previous one.
- R6: Status bit 0 (horizontal mismatch) is set when a horizontal measurement equals the previous one but differs from exp_h.
- R7: Status bit 1 (vertical mismatch) is set when a vertical measurement equals the previous one but differs from exp_v.
- R8: No flag is set until at least two complete measurements of its axis exist after reset.
- R9: A write with wr_addr 0 clears each status bit whose wr_data bit is one. Bits written with zero are unaffected. Otherwise the flags hold their value.
- R10: If a flag's set event and its clear write fall in the same cycle, the flag ends up set.
- R11: A read is issued with rd_en. One cycle later rd_data holds the result: status in bits 3:0 for rd_addr 0, {det_v, det_h} for rd_addr 1, and zero for any other address. rd_data holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Recovered horizontal sync, active high |
| vsync | input | 1 | Recovered vertical sync, active high |
| de | input | 1 | Data enable, high on active pixels |
| exp_h | input | CNT_W | Expected active pixels per line |
| exp_v | input | CNT_W | Expected active lines per frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data (write one to clear) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| det_h | output | CNT_W | Detected active pixels per line |
| det_v | output | CNT_W | Detected active lines per frame |
| status | output | 4 | Sticky flags {v_oos, h_oos, v_mismatch, h_mismatch} |

## Verification
The bench starts each check from a fresh reset. It first runs frames with a single active line, to show that one measurement alone raises no flag. A design that compares against an empty history would raise a mismatch immediately. It then inserts one line with an extra pixel and one frame with an extra line. Only the out-of-sync bits must rise. A design that folded instability into mismatch, or that counted blanking lines as zero-length lines, would set the wrong bits. It also aligns a clear write with the very cycle a mismatch is set, where a clear-priority design would lose the event. Finally, it writes zero and partial masks to show that no other bit is disturbed.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  localparam int NFLAGS   = 4;
  localparam int BIT_HMM  = 0;
  localparam int BIT_VMM  = 1;
  localparam int BIT_HOOS = 2;
  localparam int BIT_VOOS = 3;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_COUNTS = 1;
  typedef logic [NFLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/vsm_meter.sv
module vsm_meter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mark,
  input  logic         tick,
  output logic [W-1:0] meas_o,
  output logic         eval_o,
  output logic         differ_o
);
  logic         mark_q;
  logic         started;
  logic         seen;
  logic [W-1:0] acc;
  logic         rise;
  logic         acc_full;

  assign rise     = mark & ~mark_q;
  assign acc_full = &acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q   <= 1'b0;
      started  <= 1'b0;
      seen     <= 1'b0;
      acc      <= '0;
      meas_o   <= '0;
      eval_o   <= 1'b0;
      differ_o <= 1'b0;
    end else begin
      mark_q <= mark;
      eval_o <= 1'b0;
      if (rise) begin
        started <= 1'b1;
        acc     <= tick ? W'(1) : '0;
        if (started && (acc != '0)) begin
          meas_o   <= acc;
          seen     <= 1'b1;
          eval_o   <= seen;
          differ_o <= (acc != meas_o);
        end
      end else if (tick && !acc_full) begin
        acc <= acc + 1'b1;
      end
    end
  end

  AST_MEAS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(meas_o)); // R2
endmodule

// File: rtl/vsm_flags.sv
module vsm_flags
  import vsm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t set_i,
  input  flag_vec_t clr_i,
  output flag_vec_t flags_o
);
  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= (flags_o & ~clr_i) | set_i;
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flags_o[i]); // R10
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flags_o[i] && !clr_i[i]) |=> flags_o[i]); // R9
    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flags_o[i]); // R9
  end
endmodule

// File: rtl/vsm_regport.sv
module vsm_regport
  import vsm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  flag_vec_t         flags_i,
  input  logic [CNT_W-1:0]  det_h_i,
  input  logic [CNT_W-1:0]  det_v_i,
  output flag_vec_t         clr_o,
  output logic [DATA_W-1:0] rd_data
);
  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[DATA_W-1:NFLAGS];

  assign clr_o = (wr_en && (wr_addr == ADDR_W'(ADDR_STATUS))) ?
                 wr_data[NFLAGS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr == ADDR_W'(ADDR_STATUS))
        rd_data <= DATA_W'(flags_i);
      else if (rd_addr == ADDR_W'(ADDR_COUNTS))
        rd_data <= DATA_W'({det_v_i, det_h_i});
      else
        rd_data <= '0;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R11
endmodule

// File: rtl/sync_stab_mon.sv
module sync_stab_mon
  import vsm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              de,
  input  logic [CNT_W-1:0]  exp_h,
  input  logic [CNT_W-1:0]  exp_v,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  det_h,
  output logic [CNT_W-1:0]  det_v,
  output logic [3:0]        status
);
  logic      de_q;
  logic      line_end;
  logic      h_eval, h_diff, v_eval, v_diff;
  flag_vec_t set_vec, clr_vec, flags;

  always_ff @(posedge clk) begin
    if (rst) de_q <= 1'b0;
    else     de_q <= de;
  end
  assign line_end = de_q & ~de;

  vsm_meter #(.W(CNT_W)) i_hmeter (
    .clk(clk), .rst(rst), .mark(hsync), .tick(de),
    .meas_o(det_h), .eval_o(h_eval), .differ_o(h_diff));

  vsm_meter #(.W(CNT_W)) i_vmeter (
    .clk(clk), .rst(rst), .mark(vsync), .tick(line_end),
    .meas_o(det_v), .eval_o(v_eval), .differ_o(v_diff));

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_HOOS] = h_eval &  h_diff;
    set_vec[BIT_VOOS] = v_eval &  v_diff;
    set_vec[BIT_HMM]  = h_eval & ~h_diff & (det_h != exp_h);
    set_vec[BIT_VMM]  = v_eval & ~v_diff & (det_v != exp_v);
  end

  vsm_flags i_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .flags_o(flags));

  vsm_regport #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regport (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .flags_i(flags), .det_h_i(det_h),
    .det_v_i(det_v), .clr_o(clr_vec), .rd_data(rd_data));

  assign status = flags;

  AST_HMM_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(status[BIT_HMM]) |-> ($past(det_h) != $past(exp_h))); // R6
  AST_VMM_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(status[BIT_VMM]) |-> ($past(det_v) != $past(exp_v))); // R7
endmodule

// File: tb/test_sync_stab_mon.sv
module test_sync_stab_mon;
  localparam int CLK_PERIOD = 10;
  localparam int P = 20;
  localparam int A = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync = 1'b0, vsync = 1'b0, de = 1'b0;
  logic [15:0] exp_h = 16'd0, exp_v = 16'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic [15:0] det_h, det_v;
  logic [3:0]  status;
  int checks = 0, failures = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_stab_mon i_sync_stab_mon (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de),
    .exp_h(exp_h), .exp_v(exp_v), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .det_h(det_h), .det_v(det_v), .status(status));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; hsync = 0; vsync = 0; de = 0; wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive_line(input int pix, input logic vs);
    for (int c = 0; c < 40; c++) begin
      hsync = (c < 4);
      de    = (c >= 8) && (c < 8 + pix);
      vsync = vs;
      @(negedge clk);
    end
  endtask

  task automatic drive_frame(input int act, input int odd_line, input int odd_pix);
    for (int l = 0; l < act + 6; l++) begin
      if (l >= 3 && l < 3 + act)
        drive_line((l - 3 == odd_line) ? odd_pix : P, l < 2);
      else
        drive_line(0, l < 2);
    end
  endtask

  task automatic trailer();
    drive_line(0, 1'b1);
    drive_line(0, 1'b1);
    drive_line(0, 1'b0);
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic reg_clear(input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", {28'd0, status}, 32'd0);
    chk("R1 det_h", {16'd0, det_h}, 32'd0);
    chk("R1 det_v", {16'd0, det_v}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
  endtask

  task automatic t_two_meas();
    exp_h = P + 1; exp_v = 16'd4;
    do_reset();
    drive_frame(1, -1, 0); trailer();
    reg_read(2'd0, rv);
    chk("R8 one measurement no flag", rv, 32'd0);
    drive_frame(1, -1, 0); trailer();
    reg_read(2'd0, rv);
    chk("R8 R6 R7 second measurement flags", rv, 32'h3);
  endtask

  task automatic t_stable();
    exp_h = P; exp_v = A;
    do_reset();
    drive_frame(A, -1, 0); drive_frame(A, -1, 0); drive_frame(A, -1, 0); trailer();
    reg_read(2'd0, rv);
    chk("R6 R7 matching stable no flag", rv, 32'd0);
    chk("R2 det_h", {16'd0, det_h}, P);
    chk("R3 det_v", {16'd0, det_v}, A);
    reg_read(2'd1, rv);
    chk("R11 counts word", rv, {16'(A), 16'(P)});
    reg_read(2'd3, rv);
    chk("R11 unmapped reads zero", rv, 32'd0);
  endtask

  task automatic t_hoos();
    exp_h = P; exp_v = A;
    do_reset();
    drive_frame(A, -1, 0); trailer();
    drive_frame(A, 2, P + 1); trailer();
    reg_read(2'd0, rv);
    chk("R4 h out of sync only", rv, 32'h4);
    chk("R2 det_h back to stable", {16'd0, det_h}, P);
    reg_clear(32'h4);
    reg_read(2'd0, rv);
    chk("R9 clear bit2", rv, 32'd0);
  endtask

  task automatic t_voos();
    exp_h = P; exp_v = A;
    do_reset();
    drive_frame(A, -1, 0); drive_frame(A, -1, 0);
    drive_frame(A + 1, -1, 0); trailer();
    reg_read(2'd0, rv);
    chk("R5 v out of sync only", rv, 32'h8);
    chk("R3 det_v odd frame", {16'd0, det_v}, A + 1);
    reg_clear(32'h0);
    reg_read(2'd0, rv);
    chk("R9 write zero keeps flag", rv, 32'h8);
    reg_clear(32'h7);
    reg_read(2'd0, rv);
    chk("R9 other bits keep flag", rv, 32'h8);
    reg_clear(32'h8);
    reg_read(2'd0, rv);
    chk("R9 clear bit3", rv, 32'd0);
  endtask

  task automatic t_mismatch();
    exp_h = P + 2; exp_v = A + 1;
    do_reset();
    drive_frame(A, -1, 0); drive_frame(A, -1, 0); trailer();
    reg_read(2'd0, rv);
    chk("R6 R7 stable mismatch", rv, 32'h3);
    reg_read(2'd1, rv);
    chk("R11 R2 R3 counts under mismatch", rv, {16'(A), 16'(P)});
  endtask

  task automatic t_set_wins();
    exp_h = P + 2; exp_v = A;
    do_reset();
    drive_frame(A, -1, 0); trailer();
    reg_clear(32'h1);
    reg_read(2'd0, rv);
    chk("R9 clear bit0", rv, 32'd0);
    for (int c = 0; c < P; c++) begin de = 1'b1; @(negedge clk); end
    de = 1'b0;
    repeat (4) @(negedge clk);
    hsync = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    hsync = 1'b0;
    @(negedge clk);
    reg_read(2'd0, rv);
    chk("R10 set wins over clear", rv, 32'h1);
    reg_clear(32'h1);
    reg_read(2'd0, rv);
    chk("R9 later clear works", rv, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_two_meas();
    t_stable();
    t_hoos();
    t_voos();
    t_mismatch();
    t_set_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule